// File: doc/BRIEF.md
# Reset Pin Glitch Detector

This block watches an active-low reset pin and separates genuine reset requests from short disturbances. The pin first passes through a flop synchronizer. A counter then measures how long the pin stays low. If the low level lasts long enough to qualify, the block emits a one-cycle valid-reset pulse for the reset sequencer.

A low level that outlasts a short notice threshold but ends before qualifying is classed as a glitch. A glitch sets a sticky flag and touches nothing else. The flag stays set until software writes a one to the clear input, or until a later assertion qualifies as a valid reset.

While the reset sequencer reports that a reset cycle is already in progress, the busy input makes the block disregard the pin completely.

Top module: `rst_glitch_det`

## Requirements
- R1: The pin passes through a two-flop synchronizer. When the pin is sampled low from clock edge E0 onward, `valid_rst` is high only in the cycle that follows edge E11, and is low in the cycle before it.
- R2: An assertion lasting one or two cycles produces no `valid_rst` pulse and leaves `glitch_flag` at 0.
- R3: An assertion lasting 3 to 9 cycles sets `glitch_flag` to 1 and produces no `valid_rst` pulse.
- R4: An assertion lasting 10 or more cycles produces exactly one `valid_rst` pulse, one cycle wide, however long the pin stays low.
- R5: A valid reset clears `glitch_flag`. In the cycle where `valid_rst` is high, `glitch_flag` reads 0.
- R6: Once set, `glitch_flag` stays at 1 through idle cycles and through later assertions of two cycles or less, as long as `sw_clr` is not asserted.
- R7: A one-cycle high on `sw_clr` clears a set `glitch_flag`.
- R8: If `sw_clr` is high in the same cycle that a glitch sets the flag, the set wins and `glitch_flag` reads 1 afterwards.
- R9: While `busy` is high, pin assertions have no effect: no pulse is produced, and no glitch is flagged.
- R10: After `rst_n` is released, `glitch_flag` and `valid_rst` are 0.
- R11: The duration count restarts at each new assertion. Two 6-cycle assertions separated by one high cycle give a glitch and no valid reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| busy | input | 1 | High while a reset cycle is already in progress |
| sw_clr | input | 1 | Write-one-to-clear strobe for the glitch flag |
| valid_rst | output | 1 | One-cycle pulse marking a qualified reset |
| glitch_flag | output | 1 | Sticky flag marking a rejected short assertion |

## Verification
The assertions take for granted that `busy` stays high for whole cycles. They also assume that `sw_clr` is a single-cycle strobe driven in step with the clock, since the sticky and clear rules are checked edge to edge. The bench changes every input at the falling clock edge only. It holds `busy` steady across each pin assertion it applies, and it raises `sw_clr` for exactly one cycle at a time. This keeps the stimulus inside those assumptions.

// File: rtl/rgd_pkg.sv
package rgd_pkg;

    // Events raised by the duration qualifier toward the flag logic
    typedef struct packed {
        logic qualify;  // count has just reached the qualification length
        logic glitch;   // pin released after notice, before qualification
    } rgd_evt_t;

    // Registered output state of the top module
    typedef struct packed {
        logic valid;
        logic flag;
    } rgd_out_t;

endpackage

// File: rtl/rgd_sync.sv
module rgd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_act
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= pin_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign pin_act = ~chain_q[STAGES-1];
endmodule

// File: rtl/rgd_qual.sv
module rgd_qual
    import rgd_pkg::*;
#(
    parameter int NOTICE_CYC = 2,
    parameter int QUAL_CYC   = 10
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_act,
    input  logic     busy,
    output rgd_evt_t evt
);
    localparam int CNT_W = $clog2(QUAL_CYC + 1);
    localparam logic [CNT_W-1:0] NOTICE_V = CNT_W'(NOTICE_CYC);
    localparam logic [CNT_W-1:0] QUAL_V   = CNT_W'(QUAL_CYC);
    localparam logic [CNT_W-1:0] PREQ_V   = CNT_W'(QUAL_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pending;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic     pin_go;

    always_comb begin
        st_d        = st_q;
        evt         = '0;
        pin_go      = pin_act && !busy;

        if (!pin_go)              st_d.cnt = '0;
        else if (st_q.cnt != QUAL_V) st_d.cnt = st_q.cnt + 1'b1;

        evt.qualify = pin_go && (st_q.cnt == PREQ_V);
        evt.glitch  = st_q.pending && !pin_act && !busy;

        if (busy)                                st_d.pending = 1'b0;
        if (pin_go && (st_q.cnt == NOTICE_V))    st_d.pending = 1'b1;
        if (evt.glitch || evt.qualify)           st_d.pending = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rst_glitch_det.sv
module rst_glitch_det
    import rgd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NOTICE_CYC  = 2,
    parameter int QUAL_CYC    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin_n,
    input  logic busy,
    input  logic sw_clr,
    output logic valid_rst,
    output logic glitch_flag
);
    logic     pin_act;
    rgd_evt_t evt;
    rgd_out_t out_d, out_q;

    rgd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (rst_pin_n),
        .pin_act (pin_act)
    );

    rgd_qual #(.NOTICE_CYC(NOTICE_CYC), .QUAL_CYC(QUAL_CYC)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_act (pin_act),
        .busy    (busy),
        .evt     (evt)
    );

    always_comb begin
        out_d.valid = evt.qualify;
        // set beats software clear; a qualified reset also clears
        out_d.flag  = evt.glitch | (out_q.flag & ~sw_clr & ~evt.qualify);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign valid_rst   = out_q.valid;
    assign glitch_flag = out_q.flag;
endmodule

// File: rtl/rst_glitch_det_chk.sv
module rst_glitch_det_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sw_clr,
    input logic valid_rst,
    input logic glitch_flag
);
    // R4: the valid pulse is one cycle wide
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_rst |=> !valid_rst);

    // R5: a valid reset leaves the flag cleared
    a_r5_valid_clears: assert property (@(posedge clk) disable iff (!rst_n)
        valid_rst |-> !glitch_flag);

    // R6: the flag holds without a software clear unless a valid reset comes
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (glitch_flag && !sw_clr) |=> (glitch_flag || valid_rst));

    // R9: busy blocks a valid pulse
    a_r9_busy_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !valid_rst);

    // R9: busy blocks a new glitch
    a_r9_busy_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !glitch_flag) |=> !glitch_flag);
endmodule

bind rst_glitch_det rst_glitch_det_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .sw_clr      (sw_clr),
    .valid_rst   (valid_rst),
    .glitch_flag (glitch_flag)
);

// File: tb/rst_glitch_det_test.sv
module rst_glitch_det_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin_n = 1'b1;
    logic busy = 1'b0;
    logic sw_clr = 1'b0;
    logic valid_rst, glitch_flag;

    int checks = 0;
    int fails = 0;
    int vpulses = 0;
    int cyc = 0;

    localparam int NV = 8;
    localparam int V_LEN  [NV] = '{1, 2, 3, 6, 9, 10, 15, 5};
    localparam int V_BUSY [NV] = '{0, 0, 0, 0, 0, 0,  0,  1};
    localparam int V_FLAG [NV] = '{0, 0, 1, 1, 1, 0,  0,  0};
    localparam int V_VAL  [NV] = '{0, 0, 0, 0, 0, 1,  1,  0};
    localparam string V_REQ [NV] = '{"R2", "R2", "R3", "R3", "R3", "R4", "R4", "R9"};

    rst_glitch_det uut (
        .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .busy(busy),
        .sw_clr(sw_clr), .valid_rst(valid_rst), .glitch_flag(glitch_flag)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (valid_rst) vpulses++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected under 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // pin low for len sampled edges; returns at the negedge where it goes high
    task automatic pulse(input int len);
        rst_pin_n = 1'b0;
        for (int i = 0; i < len; i++) @(negedge clk);
        rst_pin_n = 1'b1;
    endtask

    task automatic clear_flag();
        sw_clr = 1'b1;
        @(negedge clk);
        sw_clr = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R10 flag", int'(glitch_flag), 0);
        chk("R10 valid", int'(valid_rst), 0);

        // vector table walk
        for (int v = 0; v < NV; v++) begin
            clear_flag();
            idle(2);
            vpulses = 0;
            busy = V_BUSY[v][0];
            pulse(V_LEN[v]);
            idle(6);
            busy = 1'b0;
            idle(2);
            chk({V_REQ[v], " flag"}, int'(glitch_flag), V_FLAG[v]);
            chk({V_REQ[v], " pulses"}, vpulses, V_VAL[v]);
        end

        // R1: latency of the valid pulse
        clear_flag();
        idle(2);
        vpulses = 0;
        rst_pin_n = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k == 11) chk("R1 before", int'(valid_rst), 0);
            if (k == 12) chk("R1 at", int'(valid_rst), 1);
        end
        rst_pin_n = 1'b1;
        idle(4);

        // R5: valid reset clears a set flag
        clear_flag();
        pulse(5); idle(4);
        chk("R5 pre", int'(glitch_flag), 1);
        pulse(12); idle(4);
        chk("R5 cleared", int'(glitch_flag), 0);

        // R6: sticky through idle and short assertions
        pulse(4); idle(4);
        idle(20);
        chk("R6 idle", int'(glitch_flag), 1);
        pulse(2); idle(4);
        chk("R6 short", int'(glitch_flag), 1);

        // R7: software clear
        clear_flag();
        idle(1);
        chk("R7 clear", int'(glitch_flag), 0);

        // R8: clear in the cycle the glitch sets the flag
        pulse(5);
        idle(2);
        clear_flag();
        chk("R8 set wins", int'(glitch_flag), 1);
        clear_flag();
        idle(1);
        chk("R8 after", int'(glitch_flag), 0);

        // R11: count restarts at each assertion
        vpulses = 0;
        pulse(6);
        idle(1);
        pulse(6);
        idle(6);
        chk("R11 pulses", vpulses, 0);
        chk("R11 flag", int'(glitch_flag), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule